// File: doc/BRIEF.md
# Dual-Clock Credit-Counter FIFO

This block moves words from a write clock domain to a read clock domain without passing pointers between them. Each side keeps its own counter. The write side counts free slots and the read side counts stored words. Every accepted transfer flips a level in its own domain. The opposite domain synchronizes that level through two flip-flops and turns the change into a one-cycle pulse. The pulse then returns one credit to that domain's counter. The synchronizer delays each credit, so full and empty can remain asserted a few cycles after the real state has changed. The error is always toward safety: there is never an overrun and never a read of an unwritten slot.

Both data interfaces are valid/ready. A word enters on a write-clock edge where `s_valid` and `s_ready` are both high. A word leaves on a read-clock edge where `m_valid` and `m_ready` are both high. `s_ready` falls when no free slot is known, and also during the pacing gap after each accepted write. `m_valid` falls when no stored word is known, and also during the pacing gap after each accepted read. The pacing gap keeps the toggles far enough apart for the other domain to see each one. `SPACING` must be chosen so that `SPACING` source cycles span at least two cycles of the slower clock. The producer may hold `s_valid` with its data for as long as it likes. The block ignores the beat until `s_ready` rises.

Top module: `cfifo_credit`

## Requirements
- R1: While reset is asserted and directly after it, `s_ready` is 1, `full` is 0, `empty` is 1 and `m_valid` is 0. At this point the free count equals `DEPTH` and the stored count is zero.
- R2: A write is accepted only on a `wclk` edge with `s_valid` and `s_ready` both high. While `s_ready` is low, `s_valid` and `s_data` do not affect the FIFO contents or the counts. `s_ready` is never high while `full` is high.
- R3: `full` goes high after the edge that accepts the write taking the last free slot.
- R4: After a write is accepted on `wclk` edge k, the read side counts the word on the third following `rclk` edge. Counting from edge k, that is two synchronizer stages plus the edge detector. If the FIFO was empty, `empty` falls after that edge.
- R5: `m_valid` is high only when `empty` is low and the read pacing gap has elapsed. While `m_valid` is high, `m_data` shows the oldest stored word. `m_ready` has no effect while `m_valid` is low.
- R6: After a read is accepted on `rclk` edge j, the freed slot is credited on the write side at the third following `wclk` edge. If `full` was high, it stays high until that edge and falls after it.
- R7: After an accepted write, `s_ready` stays low for the next `SPACING-1` `wclk` edges. After an accepted read, `m_valid` stays low for the next `SPACING-1` `rclk` edges.
- R8: When a local transfer and an incoming credit pulse fall on the same edge, that domain's counter keeps its value.
- R9: Words leave in the order they were accepted, including across address wrap-around, for any fill level from 1 to `DEPTH`.
- R10: Neither counter ever exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low |
| s_valid | input | 1 | Write data valid |
| s_ready | output | 1 | FIFO can accept a word this cycle |
| s_data | input | DW | Write data |
| full | output | 1 | Write side sees no free slot |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low |
| m_valid | output | 1 | Read data valid |
| m_ready | input | 1 | Consumer takes the word this cycle |
| m_data | output | DW | Oldest stored word |
| empty | output | 1 | Read side sees no stored word |

## Verification
The assertions check on every cycle the following properties:
- `s_ready` is never high while `full` is high, and `m_valid` is never high while `empty` is high.
- Every accepted transfer is followed by a pacing gap.
- Counters stay within bounds, and a counter holds its value when a transfer and a credit pulse share an edge.
- `full` and `empty` release only after a credit pulse.

The exact three-edge credit latency, the data ordering across wrap-around at every fill level, and the discarding of beats offered while not ready are shown only by the bench's sweeps. The bench runs with both domains on one clock so that every latency falls on a known cycle.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

  // Synchronizer depth before the edge-detect stage.
  localparam int unsigned SYNC_FLOPS = 2;

  // Next credit value: a local take and a remote return on the same edge cancel.
  function automatic logic [31:0] credit_next(input logic [31:0] cur,
                                              input logic take,
                                              input logic give);
    logic [31:0] nxt;
    nxt = cur;
    if (give && !take) nxt = cur + 32'd1;
    else if (take && !give) nxt = cur - 32'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/cfifo_toggle_sync.sv
module cfifo_toggle_sync
  import cfifo_pkg::*;
(
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  localparam int unsigned N = SYNC_FLOPS;

  logic       src_level;
  logic [N:0] chain;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) src_level <= 1'b0;
    else if (src_pulse) src_level <= ~src_level;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) chain <= '0;
    else chain <= {chain[N-1:0], src_level};
  end

  assign dst_pulse = chain[N] ^ chain[N-1];

endmodule

// File: rtl/cfifo_credit_ctr.sv
module cfifo_credit_ctr
  import cfifo_pkg::*;
#(
  parameter int unsigned CW   = 3,
  parameter int unsigned INIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] cnt,
  output logic          none
);
  logic [31:0] nxt;

  always_comb nxt = credit_next(32'(cnt), take, give);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= CW'(INIT);
    else cnt <= nxt[CW-1:0];
  end

  assign none = (cnt == '0);

endmodule

// File: rtl/cfifo_pace.sv
module cfifo_pace #(
  parameter int unsigned SPACING = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic open_o
);
  localparam int unsigned GW = (SPACING > 2) ? $clog2(SPACING) : 1;

  logic [GW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (fire) wait_cnt <= GW'(SPACING - 1);
    else if (wait_cnt != '0) wait_cnt <= wait_cnt - GW'(1);
  end

  assign open_o = (wait_cnt == '0);

endmodule

// File: rtl/cfifo_store.sv
module cfifo_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 2
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cfifo_credit.sv
module cfifo_credit #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned DW      = 8,
  parameter int unsigned SPACING = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          empty
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          w_fire, r_fire;
  logic          w_open, r_open;
  logic          rd_seen_w, wr_seen_r;
  logic [CW-1:0] free_cnt, valid_cnt;
  logic          free_none, valid_none;
  logic [AW-1:0] waddr, raddr;

  // Write domain
  assign s_ready = !free_none && w_open;
  assign w_fire  = s_valid && s_ready;
  assign full    = free_none;

  cfifo_pace #(.SPACING(SPACING)) w_pace_i (
    .clk(wclk), .rst_n(wrst_n), .fire(w_fire), .open_o(w_open)
  );

  cfifo_credit_ctr #(.CW(CW), .INIT(DEPTH)) free_ctr_i (
    .clk(wclk), .rst_n(wrst_n), .take(w_fire), .give(rd_seen_w),
    .cnt(free_cnt), .none(free_none)
  );

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) waddr <= '0;
    else if (w_fire) waddr <= (waddr == AW'(DEPTH - 1)) ? '0 : waddr + AW'(1);
  end

  // Read domain
  assign m_valid = !valid_none && r_open;
  assign r_fire  = m_valid && m_ready;
  assign empty   = valid_none;

  cfifo_pace #(.SPACING(SPACING)) r_pace_i (
    .clk(rclk), .rst_n(rrst_n), .fire(r_fire), .open_o(r_open)
  );

  cfifo_credit_ctr #(.CW(CW), .INIT(0)) valid_ctr_i (
    .clk(rclk), .rst_n(rrst_n), .take(r_fire), .give(wr_seen_r),
    .cnt(valid_cnt), .none(valid_none)
  );

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) raddr <= '0;
    else if (r_fire) raddr <= (raddr == AW'(DEPTH - 1)) ? '0 : raddr + AW'(1);
  end

  // Crossings
  cfifo_toggle_sync w2r_i (
    .src_clk(wclk), .src_rst_n(wrst_n), .src_pulse(w_fire),
    .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_pulse(wr_seen_r)
  );

  cfifo_toggle_sync r2w_i (
    .src_clk(rclk), .src_rst_n(rrst_n), .src_pulse(r_fire),
    .dst_clk(wclk), .dst_rst_n(wrst_n), .dst_pulse(rd_seen_w)
  );

  // Storage
  cfifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) store_i (
    .wclk(wclk), .we(w_fire), .waddr(waddr), .wdata(s_data),
    .raddr(raddr), .rdata(m_data)
  );

endmodule

// File: rtl/cfifo_credit_chk.sv
module cfifo_credit_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          full,
  input logic          m_valid,
  input logic          m_ready,
  input logic          empty,
  input logic [CW-1:0] free_cnt,
  input logic [CW-1:0] valid_cnt,
  input logic          rd_seen_w,
  input logic          wr_seen_r
);

  a_r2_no_ready_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> !s_ready);

  a_r3_full_after_last: assert property (@(posedge wclk) disable iff (!wrst_n)
    (s_valid && s_ready && free_cnt == CW'(1) && !rd_seen_w) |=> full);

  a_r5_valid_needs_data: assert property (@(posedge rclk) disable iff (!rrst_n)
    m_valid |-> !empty);

  a_r7_write_gap: assert property (@(posedge wclk) disable iff (!wrst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r7_read_gap: assert property (@(posedge rclk) disable iff (!rrst_n)
    (m_valid && m_ready) |=> !m_valid);

  a_r6_full_release: assert property (@(posedge wclk) disable iff (!wrst_n)
    $fell(full) |-> $past(rd_seen_w));

  a_r4_empty_release: assert property (@(posedge rclk) disable iff (!rrst_n)
    $fell(empty) |-> $past(wr_seen_r));

  a_r8_write_side_hold: assert property (@(posedge wclk) disable iff (!wrst_n)
    (s_valid && s_ready && rd_seen_w) |=> $stable(free_cnt));

  a_r8_read_side_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    (m_valid && m_ready && wr_seen_r) |=> $stable(valid_cnt));

  a_r10_free_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
    free_cnt <= CW'(DEPTH));

  a_r10_valid_bound: assert property (@(posedge rclk) disable iff (!rrst_n)
    valid_cnt <= CW'(DEPTH));

endmodule

bind cfifo_credit cfifo_credit_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .s_valid(s_valid), .s_ready(s_ready), .full(full),
  .m_valid(m_valid), .m_ready(m_ready), .empty(empty),
  .free_cnt(free_cnt), .valid_cnt(valid_cnt),
  .rd_seen_w(rd_seen_w), .wr_seen_r(wr_seen_r)
);

// File: tb/cfifo_credit_tb_top.sv
module cfifo_credit_tb_top;
  localparam int DEPTH = 4;
  localparam int DW    = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, s_valid, s_ready, full, m_valid, m_ready, empty;
  logic [DW-1:0] s_data, m_data;

  int  errs = 0;
  int  checks = 0;
  bit  done = 0;
  logic [DW-1:0] model_q[$];
  logic [DW-1:0] got;

  cfifo_credit #(.DEPTH(DEPTH), .DW(DW), .SPACING(3)) dut_i (
    .wclk(clk), .wrst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .full(full),
    .rclk(clk), .rrst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .empty(empty)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  task automatic push(input logic [DW-1:0] d);
    while (!s_ready) step();
    s_valid = 1'b1;
    s_data  = d;
    step();
    s_valid = 1'b0;
    model_q.push_back(d);
  endtask

  task automatic pop();
    logic [DW-1:0] exp;
    while (!m_valid) step();
    exp = (model_q.size() > 0) ? model_q.pop_front() : 'x;
    chk("R9", 32'(m_data), 32'(exp), "read order");
    m_ready = 1'b1;
    step();
    m_ready = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0; s_data = '0;
    repeat (3) step();
    chk("R1", 32'(s_ready), 1, "s_ready in reset");
    chk("R1", 32'(empty), 1, "empty in reset");
    rst_n = 1'b1;
    step();
    chk("R1", 32'(s_ready), 1, "s_ready after reset");
    chk("R1", 32'(full), 0, "full after reset");
    chk("R1", 32'(empty), 1, "empty after reset");
    chk("R1", 32'(m_valid), 0, "m_valid after reset");

    // Single word: pacing gap and crossing latency
    push(8'hA5);
    chk("R7", 32'(s_ready), 0, "gap edge+0");
    chk("R4", 32'(empty), 1, "empty edge+0");
    step();
    chk("R7", 32'(s_ready), 0, "gap edge+1");
    chk("R4", 32'(empty), 1, "empty edge+1");
    step();
    chk("R7", 32'(s_ready), 1, "gap over edge+2");
    chk("R4", 32'(empty), 1, "empty edge+2");
    step();
    chk("R4", 32'(empty), 0, "empty falls edge+3");
    chk("R5", 32'(m_valid), 1, "m_valid edge+3");
    chk("R5", 32'(m_data), 32'h A5, "head data");
    pop();
    chk("R7", 32'(m_valid), 0, "read gap");
    chk("R5", 32'(empty), 1, "empty after last read");
    settle();

    // Sweep over every fill level, twice, so addresses wrap
    for (int rnd = 0; rnd < 2; rnd++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        for (int i = 0; i < n; i++) push(DW'((rnd << 6) | (n << 3) | i));
        chk("R3", 32'(full), (n == DEPTH) ? 1 : 0, "full after fill");
        settle();
        chk("R4", 32'(empty), 0, "empty after fill");
        if (n == DEPTH) begin
          // Offers while not ready are discarded
          s_valid = 1'b1; s_data = 8'hEE;
          for (int k = 0; k < 5; k++) begin
            step();
            chk("R2", 32'(s_ready), 0, "ready while full");
          end
          s_valid = 1'b0;
          pop();
          chk("R6", 32'(full), 1, "full edge+0");
          step();
          chk("R6", 32'(full), 1, "full edge+1");
          step();
          chk("R6", 32'(full), 1, "full edge+2");
          step();
          chk("R6", 32'(full), 0, "full released edge+3");
          for (int i = 1; i < n; i++) pop();
        end else begin
          for (int i = 0; i < n; i++) pop();
        end
        chk("R2", 32'(model_q.size()), 0, "model drained");
        settle();
        chk("R5", 32'(empty), 1, "empty after drain");
        chk("R6", 32'(s_ready), 1, "credits back");
        // Reads offered while empty do nothing
        m_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
          step();
          chk("R5", 32'(m_valid), 0, "m_valid while empty");
        end
        m_ready = 1'b0;
      end
    end

    // Same-edge credit and take on the write side
    for (int i = 0; i < DEPTH - 1; i++) push(DW'(8'h30 + i));
    settle();
    chk("R8", 32'(full), 0, "one slot left");
    pop();
    step();
    step();
    chk("R8", 32'(s_ready), 1, "ready before coincident write");
    s_valid = 1'b1; s_data = 8'h3F;
    step();
    s_valid = 1'b0;
    model_q.push_back(8'h3F);
    chk("R8", 32'(full), 0, "free count held on coincidence");
    settle();
    chk("R8", 32'(full), 0, "still one slot");

    // Same-edge credit and take on the read side
    for (int i = 0; i < DEPTH - 2; i++) pop();
    settle();
    chk("R8", 32'(empty), 0, "one word left");
    push(8'h55);
    step();
    step();
    chk("R8", 32'(m_valid), 1, "valid before coincident read");
    chk("R9", 32'(m_data), 32'(model_q[0]), "coincident read data");
    void'(model_q.pop_front());
    m_ready = 1'b1;
    step();
    m_ready = 1'b0;
    chk("R8", 32'(empty), 0, "valid count held on coincidence");
    settle();
    pop();
    chk("R8", 32'(empty), 1, "empty after final read");
    settle();
    chk("R1", 32'(full), 0, "idle full");

    done = 1;
    report();
    $finish;
  end

endmodule